// File: doc/BRIEF.md
# Four-Phase Request/Acknowledge Transfer Link

This block joins a bus initiator and a bus target through a fully interlocked four-phase handshake. The two sides share no timing assumption. Each one samples the other's control line through its own synchronizer chain. Both sides are modelled as synchronous logic on one clock, so the link behaves like two independently timed agents.

The initiator takes a command when it is idle and puts the address, the direction and any write data on the bus. It holds them for a fixed address-decode interval and then raises its request. The target answers with an acknowledge:
- On a write, it stores the data before acknowledging.
- On a read, it drives its stored word before acknowledging, and stops driving that word once the request has fallen.

The initiator drops its request when it sees the acknowledge, and captures read data at that same moment. The target then drops the acknowledge. When the initiator sees the acknowledge fall, it reports completion with a one-cycle pulse and becomes free for the next address. Bus ownership is assumed; there is no arbitration.

Top module: `hs_link`

## Requirements
- R1: While reset is high and in the first cycle after it, cmd_ready is 1 and done, bus_req and bus_ack are 0. The target's storage reads as all zeros.
- R2: A command is taken at a clock edge where cmd_valid and cmd_ready are both 1. cmd_ready is then 0 until the edge that raises done.
- R3: bus_req rises exactly DECODE_CYC cycles after the edge that took the command. bus_addr holds the command's address from that edge until done.
- R4: bus_ack rises SYNC_STAGES+1 cycles after bus_req rises.
- R5: bus_req falls SYNC_STAGES+1 cycles after bus_ack rises.
- R6: bus_ack falls SYNC_STAGES+1 cycles after bus_req falls.
- R7: done is high for exactly one cycle, SYNC_STAGES+1 cycles after bus_ack falls. bus_req and bus_ack are both 0 at that point.
- R8: The command fields are cmd_rd (1 = read, 0 = write), cmd_addr and cmd_wdata. A write stores cmd_wdata at cmd_addr in a target holding 2^ADDR_W words. A later read of that address returns the stored word on rdata while done is high.
- R9: bus_rdata carries the addressed word only while bus_ack is high during a read. At all other times it is zero.
- R10: A write transfer leaves rdata unchanged.
- R11: cmd_valid asserted while cmd_ready is 0 is ignored. It changes neither bus_addr nor any stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | ADDR_W | Target word address |
| cmd_wdata | input | DATA_W | Write data |
| cmd_ready | output | 1 | Initiator idle, command can be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Data of the last read |
| bus_req | output | 1 | Bus request line |
| bus_ack | output | 1 | Bus acknowledge line |
| bus_addr | output | ADDR_W | Address on the bus |
| bus_rdata | output | DATA_W | Read data driven by the target |

## Verification
The command-taking edge is counted as edge 0, and each result is due at a fixed edge after it:
- bus_req rises at edge DECODE_CYC.
- Each later phase follows SYNC_STAGES+1 edges after the one before it: two synchronizer flops plus the flop that drives the line.
- done and the read data therefore land at DECODE_CYC+4·(SYNC_STAGES+1), which is edge 14 with the defaults.

The bench counts edges from the command edge and samples on the falling clock edge after each one. It compares every handshake line, bus_addr, bus_rdata, cmd_ready and done against the edge-indexed expectation over the whole transfer, so a phase that arrives one cycle early or late is caught.

// File: rtl/hs_pkg.sv
package hs_pkg;

    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        logic  rd;
        addr_t addr;
        data_t wdata;
    } hs_cmd_t;

    typedef enum logic [1:0] {
        M_IDLE    = 2'd0,
        M_SETUP   = 2'd1,
        M_REQ     = 2'd2,
        M_RELEASE = 2'd3
    } mst_state_t;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_ACK  = 1'b1
    } slv_state_t;

    function automatic data_t gate_data(input logic en, input data_t d);
        return en ? d : '0;
    endfunction

endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_master.sv
module hs_master
    import hs_pkg::*;
#(
    parameter int DECODE_CYC = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cmd_valid,
    input  hs_cmd_t cmd,
    output logic    cmd_ready,
    output logic    done,
    output data_t   rdata,
    output logic    bus_req,
    output hs_cmd_t bus_cmd,
    input  logic    ack_s,
    input  data_t   bus_rdata
);
    localparam int               CW       = $clog2(DECODE_CYC + 1);
    localparam logic [CW-1:0]    CNT_LAST = CW'(DECODE_CYC - 1);
    localparam int               AGE_W    = $clog2(DECODE_CYC + 2) + 1;
    localparam logic [AGE_W-1:0] AGE_MAX  = '1;

    mst_state_t    state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= M_IDLE;
            cnt     <= '0;
            bus_req <= 1'b0;
            done    <= 1'b0;
            bus_cmd <= '0;
            rdata   <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                M_IDLE: begin
                    if (cmd_valid) begin
                        bus_cmd <= cmd;
                        cnt     <= '0;
                        state   <= M_SETUP;
                    end
                end
                M_SETUP: begin
                    if (cnt == CNT_LAST) begin
                        bus_req <= 1'b1;
                        state   <= M_REQ;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                M_REQ: begin
                    if (ack_s) begin
                        bus_req <= 1'b0;
                        if (bus_cmd.rd) rdata <= bus_rdata;
                        state <= M_RELEASE;
                    end
                end
                M_RELEASE: begin
                    if (!ack_s) begin
                        done  <= 1'b1;
                        state <= M_IDLE;
                    end
                end
                default: state <= M_IDLE;
            endcase
        end
    end

    assign cmd_ready = (state == M_IDLE);

    // Checker-side counter: cycles since the command was taken
    logic [AGE_W-1:0] age;
    always_ff @(posedge clk) begin
        if (rst)                         age <= AGE_MAX;
        else if (cmd_ready && cmd_valid) age <= '0;
        else if (age != AGE_MAX)         age <= age + 1'b1;
    end

    assert_decode_delay_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> age == AGE_W'(DECODE_CYC));

    assert_req_drop_after_ack_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_req) |-> $past(ack_s));

    assert_req_raise_ack_low_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_req) |-> !$past(ack_s));
endmodule

// File: rtl/hs_slave.sv
module hs_slave
    import hs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req_s,
    input  hs_cmd_t bus_cmd,
    output logic    bus_ack,
    output data_t   bus_rdata
);
    slv_state_t state;
    data_t      mem [DEPTH];
    data_t      rd_q;
    logic       drv;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            bus_ack <= 1'b0;
            rd_q    <= '0;
            drv     <= 1'b0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_s) begin
                        if (bus_cmd.rd) begin
                            rd_q <= mem[bus_cmd.addr];
                            drv  <= 1'b1;
                        end else begin
                            mem[bus_cmd.addr] <= bus_cmd.wdata;
                        end
                        bus_ack <= 1'b1;
                        state   <= S_ACK;
                    end
                end
                S_ACK: begin
                    if (!req_s) begin
                        bus_ack <= 1'b0;
                        drv     <= 1'b0;
                        state   <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign bus_rdata = gate_data(drv, rd_q);

    assert_ack_after_req_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_ack) |-> $past(req_s));

    assert_ack_release_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_ack) |-> !$past(req_s));

    assert_rdata_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_ack |-> bus_rdata == '0);
endmodule

// File: rtl/hs_link.sv
module hs_link
    import hs_pkg::*;
#(
    parameter int DECODE_CYC  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic              cmd_rd,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              cmd_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic              bus_req,
    output logic              bus_ack,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_rdata
);
    hs_cmd_t cmd_in;
    hs_cmd_t bus_cmd;
    logic    req_s;
    logic    ack_s;

    assign cmd_in = '{rd: cmd_rd, addr: cmd_addr, wdata: cmd_wdata};

    hs_master #(.DECODE_CYC(DECODE_CYC)) master_i (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd       (cmd_in),
        .cmd_ready (cmd_ready),
        .done      (done),
        .rdata     (rdata),
        .bus_req   (bus_req),
        .bus_cmd   (bus_cmd),
        .ack_s     (ack_s),
        .bus_rdata (bus_rdata)
    );

    hs_sync #(.STAGES(SYNC_STAGES)) req_sync_i (
        .clk (clk), .rst (rst), .d (bus_req), .q (req_s)
    );

    hs_sync #(.STAGES(SYNC_STAGES)) ack_sync_i (
        .clk (clk), .rst (rst), .d (bus_ack), .q (ack_s)
    );

    hs_slave slave_i (
        .clk       (clk),
        .rst       (rst),
        .req_s     (req_s),
        .bus_cmd   (bus_cmd),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata)
    );

    assign bus_addr = bus_cmd.addr;

    assert_done_lines_low_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!bus_req && !bus_ack));

    assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!cmd_ready && $past(!cmd_ready)) |-> $stable(bus_addr));

    assert_busy_until_done_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_ready) |-> done);
endmodule

// File: tb/hs_link_tb.sv
`timescale 1ns/1ps
module hs_link_tb_top;
    localparam int D      = 2;
    localparam int S      = 2;
    localparam int PH     = S + 1;
    localparam int DONE_K = D + 4 * PH;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic       cmd_rd = 1'b0;
    logic [2:0] cmd_addr = '0;
    logic [7:0] cmd_wdata = '0;
    logic       cmd_ready, done, bus_req, bus_ack;
    logic [7:0] rdata, bus_rdata;
    logic [2:0] bus_addr;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   finished = 0;
    logic [7:0] mem_m [8];
    logic [7:0] last_rd = '0;

    always #2.5 clk = ~clk;

    hs_link #(.DECODE_CYC(D), .SYNC_STAGES(S)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_rd(cmd_rd),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
        .done(done), .rdata(rdata), .bus_req(bus_req), .bus_ack(bus_ack),
        .bus_addr(bus_addr), .bus_rdata(bus_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic xfer(input logic rd, input logic [2:0] a, input logic [7:0] wd, input bit junk);
        logic [7:0] rd_exp;
        rd_exp = rd ? mem_m[a] : last_rd;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R2 ready before command", cmd_ready, 1);
        cmd_valid = 1'b1; cmd_rd = rd; cmd_addr = a; cmd_wdata = wd;
        @(posedge clk);
        for (int k = 0; k <= DONE_K; k++) begin
            bit req_e, ack_e;
            @(negedge clk);
            if (k == 0) cmd_valid = 1'b0;
            if (junk && k == 3) begin
                cmd_valid = 1'b1; cmd_rd = 1'b0; cmd_addr = ~a; cmd_wdata = ~wd;
            end
            if (junk && k == DONE_K - 2) cmd_valid = 1'b0;
            req_e = (k >= D) && (k < D + 2 * PH);
            ack_e = (k >= D + PH) && (k < D + 3 * PH);
            chk(bus_req == req_e, "R3/R5 bus_req timing", bus_req, req_e);
            chk(bus_ack == ack_e, "R4/R6 bus_ack timing", bus_ack, ack_e);
            chk(done == (k == DONE_K), "R7 done pulse", done, k == DONE_K);
            chk(cmd_ready == (k == DONE_K), "R2 busy window", cmd_ready, k == DONE_K);
            chk(bus_addr == a, "R3 R11 address hold", bus_addr, a);
            chk(bus_rdata == ((ack_e && rd) ? rd_exp : 8'h00), "R9 bus read data",
                bus_rdata, (ack_e && rd) ? rd_exp : 0);
            if (k == DONE_K)
                chk(rdata == rd_exp, rd ? "R8 read result" : "R10 write keeps rdata",
                    rdata, rd_exp);
        end
        if (rd) last_rd = rd_exp;
        else    mem_m[a] = wd;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=hang expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) mem_m[i] = '0;
        repeat (4) @(negedge clk);
        chk(cmd_ready == 1'b1, "R1 reset ready", cmd_ready, 1);
        chk(done == 1'b0, "R1 reset done", done, 0);
        chk(bus_req == 1'b0, "R1 reset req", bus_req, 0);
        chk(bus_ack == 1'b0, "R1 reset ack", bus_ack, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_ready == 1'b1 && !bus_req && !bus_ack && !done, "R1 after reset", 0, 0);
        xfer(1'b1, 3'd5, 8'h00, 1'b0);             // R1 storage starts at zero
        for (int a = 0; a < 8; a++) xfer(1'b0, 3'(a), 8'((a * 29 + 7) & 255), 1'b0);
        for (int a = 0; a < 8; a++) xfer(1'b1, 3'(a), 8'h00, 1'b0);
        xfer(1'b0, 3'd3, 8'hA5, 1'b1);             // R11 junk offered while busy
        xfer(1'b1, 3'd4, 8'h00, 1'b0);             // R11 ~3 untouched
        xfer(1'b1, 3'd3, 8'h00, 1'b0);
        xfer(1'b0, 3'd0, 8'hFF, 1'b0);
        xfer(1'b0, 3'd7, 8'h00, 1'b0);             // R10 rdata unchanged by write
        xfer(1'b1, 3'd0, 8'h00, 1'b0);
        xfer(1'b1, 3'd7, 8'h00, 1'b0);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule